// File: doc/BRIEF.md
# Prefix-Fill Magnitude Comparator

This block compares two unsigned operands of configurable width in a single combinational pass. It raises exactly one of three flags: first operand greater, first operand smaller, or both equal. It contains no priority encoder. It first splits the operands into two disjoint "wins here" vectors. One vector marks the positions where the first operand holds a 1 against a 0. The other marks the reverse case.

Each wins vector then becomes a fill mask. The mask has ones only at the positions strictly above that vector's leading one. The leading one and every bit below it are zero. The two masks are crossed against each other: one mask is inverted and ANDed with the other, in both directions. An OR over each crossed vector shows which operand owns the most significant differing bit. A separate zero test on the union of the two wins vectors gives the equal flag.

The fill step builds its prefix OR in one of two forms, chosen by a parameter. One is a linear chain, the other a doubling network. Both forms produce the same flags.

Top module: `prefix_fill_comparator`

## Requirements
- R1: `gt` is 1 exactly when `a_in` is greater than `b_in`, with both treated as unsigned integers of WIDTH bits.
- R2: `lt` is 1 exactly when `a_in` is less than `b_in` (unsigned).
- R3: `eq` is 1 exactly when every bit of `a_in` equals the matching bit of `b_in`.
- R4: For every input pair, exactly one of `gt`, `lt`, `eq` is 1.
- R5: The flags depend only on the most significant bit position where the operands differ and on which operand holds the 1 there. Changing any bits below that position in either operand leaves the flags unchanged.
- R6: The block is purely combinational. The flags follow a change of the inputs in the same time step, with no clock and no stored state.
- R7: Bit WIDTH-1 carries the most weight. An operand whose top bit is 1 is greater than one whose top bit is 0, whatever the lower bits are. At the 64-bit default width, 2^63 is greater than 2^63-1.
- R8: The ripple fill style (SCAN_STYLE = SCAN_RIPPLE) and the doubling fill style (SCAN_STYLE = SCAN_DOUBLING) give identical flags for every input pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| gt | output | 1 | First operand is greater |
| lt | output | 1 | First operand is smaller |
| eq | output | 1 | Operands are equal |

## Verification
At 6 bits the bench sweeps every operand pair through both fill styles and compares the flags with plain relational operators. An off-by-one fill that kept or dropped the leading one would invert results whenever the operands differ in a single position. Equal pairs drive both fills to all ones, so a design without the separate equal test would report neither or both flags. At 64 bits, random pairs and pairs that share a common prefix and then get scrambled lower bits target the top-bit weighting and the low-bit independence. A fill chain that stopped short of the top bit, or a crossing wired the wrong way round, would flip those results.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    SCAN_RIPPLE   = 1'b0,
    SCAN_DOUBLING = 1'b1
  } scan_e;

  function automatic int unsigned scan_levels(input int unsigned width);
    return (width <= 1) ? 1 : $clog2(width);
  endfunction
endpackage

// File: rtl/cmp_wins_split.sv
module cmp_wins_split #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] b_val,
  output logic [WIDTH-1:0] a_wins,
  output logic [WIDTH-1:0] b_wins,
  output logic             all_same
);
  always_comb begin
    a_wins   = a_val & ~b_val;
    b_wins   = ~a_val & b_val;
    all_same = ~|(a_wins | b_wins);
  end

  // R1/R2: a position can favour only one operand
  always_comb begin
    assert_wins_disjoint_R1: assert ((a_wins & b_wins) == '0)
      else $error("wins vectors overlap");
  end
endmodule

// File: rtl/cmp_prefix_fill.sv
module cmp_prefix_fill
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH      = 64,
  parameter scan_e       SCAN_STYLE = SCAN_DOUBLING
) (
  input  logic [WIDTH-1:0] wins,
  output logic [WIDTH-1:0] fill
);
  localparam int unsigned LEVELS = scan_levels(WIDTH);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] seen_above;

  generate
    if (SCAN_STYLE == SCAN_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] chain;
      assign chain[WIDTH-1] = wins[WIDTH-1];
      for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_bit
        assign chain[i] = chain[i+1] | wins[i];
      end
      assign seen_above = chain;
    end else begin : g_doubling
      logic [WIDTH-1:0] stage [0:LEVELS];
      assign stage[0] = wins;
      for (genvar l = 0; l < LEVELS; l++) begin : g_level
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
          if (i + (1 << l) < WIDTH) begin : g_merge
            assign stage[l+1][i] = stage[l][i] | stage[l][i + (1 << l)];
          end else begin : g_pass
            assign stage[l+1][i] = stage[l][i];
          end
        end
      end
      assign seen_above = stage[LEVELS];
    end
  endgenerate

  assign fill = ~seen_above;

  // R5: the leading one and all lower bits are cleared, and the fill is a
  // solid run of ones starting at the top
  always_comb begin
    assert_fill_clears_lead_R5: assert ((fill & wins) == '0)
      else $error("fill overlaps a set wins bit");
    assert_fill_contiguous_R5: assert (((fill & ~(fill >> 1)) & ~TOP_BIT) == '0)
      else $error("fill has a gap");
  end
endmodule

// File: rtl/cmp_cross_reduce.sv
module cmp_cross_reduce #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_fill,
  input  logic [WIDTH-1:0] b_fill,
  input  logic             all_same,
  output logic             a_greater,
  output logic             b_greater
);
  logic [WIDTH-1:0] a_cross;
  logic [WIDTH-1:0] b_cross;

  always_comb begin
    a_cross   = ~a_fill & b_fill;
    b_cross   = a_fill & ~b_fill;
    a_greater = (|a_cross) & ~all_same;
    b_greater = (|b_cross) & ~all_same;
  end

  // R4: the two crossed vectors never both carry a one
  always_comb begin
    assert_cross_exclusive_R4: assert (!((|a_cross) && (|b_cross)))
      else $error("both crossings nonzero");
  end
endmodule

// File: rtl/prefix_fill_comparator.sv
module prefix_fill_comparator
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH      = 64,
  parameter scan_e       SCAN_STYLE = SCAN_DOUBLING
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             gt,
  output logic             lt,
  output logic             eq
);
  logic [WIDTH-1:0] a_wins;
  logic [WIDTH-1:0] b_wins;
  logic [WIDTH-1:0] a_fill;
  logic [WIDTH-1:0] b_fill;
  logic             all_same;
  logic             a_greater;
  logic             b_greater;

  cmp_wins_split #(.WIDTH(WIDTH)) u_split (
    .a_val   (a_in),
    .b_val   (b_in),
    .a_wins  (a_wins),
    .b_wins  (b_wins),
    .all_same(all_same)
  );

  cmp_prefix_fill #(.WIDTH(WIDTH), .SCAN_STYLE(SCAN_STYLE)) u_fill_a (
    .wins(a_wins),
    .fill(a_fill)
  );

  cmp_prefix_fill #(.WIDTH(WIDTH), .SCAN_STYLE(SCAN_STYLE)) u_fill_b (
    .wins(b_wins),
    .fill(b_fill)
  );

  cmp_cross_reduce #(.WIDTH(WIDTH)) u_cross (
    .a_fill   (a_fill),
    .b_fill   (b_fill),
    .all_same (all_same),
    .a_greater(a_greater),
    .b_greater(b_greater)
  );

  assign gt = a_greater;
  assign lt = b_greater;
  assign eq = all_same;

  always_comb begin
    assert_one_flag_R4: assert ($countones({gt, lt, eq}) == 1)
      else $error("flags not one-hot");
    assert_eq_matches_R3: assert (eq == (a_in == b_in))
      else $error("equal flag wrong");
    assert_gt_matches_R1: assert (gt == (a_in > b_in))
      else $error("greater flag wrong");
    assert_lt_matches_R2: assert (lt == (a_in < b_in))
      else $error("smaller flag wrong");
  end
endmodule

// File: tb/test_prefix_fill_comparator.sv
module test_prefix_fill_comparator;
  import cmp_pkg::*;

  localparam int SMALL_W = 6;
  localparam int WIDE_W  = 64;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  logic [SMALL_W-1:0] sa, sb;
  logic [WIDE_W-1:0]  wa, wb;
  logic s_gt_r, s_lt_r, s_eq_r, s_gt_d, s_lt_d, s_eq_d;
  logic w_gt_r, w_lt_r, w_eq_r, gt, lt, eq;

  prefix_fill_comparator #(.WIDTH(SMALL_W), .SCAN_STYLE(SCAN_RIPPLE)) i_small_ripple (
    .a_in(sa), .b_in(sb), .gt(s_gt_r), .lt(s_lt_r), .eq(s_eq_r));
  prefix_fill_comparator #(.WIDTH(SMALL_W), .SCAN_STYLE(SCAN_DOUBLING)) i_small_doubling (
    .a_in(sa), .b_in(sb), .gt(s_gt_d), .lt(s_lt_d), .eq(s_eq_d));
  prefix_fill_comparator #(.WIDTH(WIDE_W), .SCAN_STYLE(SCAN_RIPPLE)) i_wide_ripple (
    .a_in(wa), .b_in(wb), .gt(w_gt_r), .lt(w_lt_r), .eq(w_eq_r));
  prefix_fill_comparator #(.WIDTH(WIDE_W), .SCAN_STYLE(SCAN_DOUBLING)) i_prefix_fill_comparator (
    .a_in(wa), .b_in(wb), .gt(gt), .lt(lt), .eq(eq));

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got gt/lt/eq=%b expected %b (a=%h b=%h)", req, got, exp, wa, wb);
    end
  endtask

  function automatic logic [2:0] expect_w(input logic [WIDE_W-1:0] x, input logic [WIDE_W-1:0] y);
    return {x > y, x < y, x == y};
  endfunction

  task automatic wide_pair(input logic [WIDE_W-1:0] x, input logic [WIDE_W-1:0] y, input string req);
    @(negedge clk);
    wa = x;
    wb = y;
    #1;
    check(req, {gt, lt, eq}, expect_w(x, y));
    check("R8", {w_gt_r, w_lt_r, w_eq_r}, {gt, lt, eq});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG_CYCLES && !finished) begin
        total++;
        bad++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    sa = '0; sb = '0; wa = '0; wb = '0;
    // R6: zero operands settle to equal with no clock edge
    #1;
    check("R6", {gt, lt, eq}, 3'b001);
    check("R3", {s_gt_r, s_lt_r, s_eq_r}, 3'b001);

    // R1 R2 R3 R4 R8: exhaustive 6-bit sweep through both fill styles
    for (int i = 0; i < (1 << SMALL_W); i++) begin
      for (int j = 0; j < (1 << SMALL_W); j++) begin
        @(negedge clk);
        sa = SMALL_W'(i);
        sb = SMALL_W'(j);
        #1;
        check(i > j ? "R1" : (i < j ? "R2" : "R3"), {s_gt_d, s_lt_d, s_eq_d},
              {i > j, i < j, i == j});
        check("R4", 3'($countones({s_gt_r, s_lt_r, s_eq_r})), 3'd1);
        check("R8", {s_gt_r, s_lt_r, s_eq_r}, {s_gt_d, s_lt_d, s_eq_d});
      end
    end

    // R7: top bit outweighs all lower bits
    wide_pair(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R7");
    wide_pair(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R7");
    wide_pair('1, '1, "R3");
    wide_pair('1, '1 - 64'd1, "R1");
    wide_pair(64'd0, 64'd1, "R2");

    // R1 R2 R3: random wide pairs
    for (int n = 0; n < 1500; n++) begin
      logic [WIDE_W-1:0] x, y;
      x = {$urandom, $urandom};
      y = (n % 5 == 0) ? x : {$urandom, $urandom};
      wide_pair(x, y, "R1");
    end

    // R5: common prefix, differing bit k, scrambled bits below k
    for (int k = 0; k < WIDE_W; k++) begin
      logic [WIDE_W-1:0] base, low_mask, x, y;
      logic [2:0] first;
      base = {$urandom, $urandom};
      low_mask = (64'd1 << k) - 64'd1;
      x = base | (64'd1 << k);
      y = base & ~(64'd1 << k);
      wide_pair(x, y, "R5");
      first = {gt, lt, eq};
      for (int r = 0; r < 4; r++) begin
        logic [WIDE_W-1:0] x2, y2;
        x2 = (x & ~low_mask) | ({$urandom, $urandom} & low_mask);
        y2 = (y & ~low_mask) | ({$urandom, $urandom} & low_mask);
        @(negedge clk);
        wa = x2;
        wb = y2;
        #1;
        check("R5", {gt, lt, eq}, first);
        check("R5", {gt, lt, eq}, 3'b100);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule